// File: doc/BRIEF.md
# Early-Exit Shift-and-Add Multiplier

This block is a free-running unsigned multiplier. It has no start input. On every pass it samples two N-bit operands and builds their 2N-bit product by shift-and-add. A pass stops as soon as no set bits remain in the shifted multiplier, so a small multiplier finishes in fewer cycles than a large one.

The finished product is double-buffered. A holding register drives the output port. On the edge that begins the next pass, the holding register takes the accumulator's final value, and on that same edge the accumulator is cleared and new operands are loaded. The product port therefore always shows the result of the last completed pass and changes only on those edges.

A Moore controller with three states sequences the datapath: load, shift with add, and shift only. It branches on two look-ahead status bits that the datapath computes from the value the multiplier register will hold after the current edge. This lets each inner iteration take exactly one clock. It also lets the zero test that ends a pass share the edge of the last shift.

Top module: `early_mult`

## Requirements
- R1: A synchronous active-high reset clears every register and puts the controller in the load state. The product output reads 0 until the first pass completes.
- R2: On a load edge, four transfers happen together. The multiplicand register takes `op_a` zero-extended to 2N bits. The multiplier register takes `op_b`. The product output takes the accumulator's value. The accumulator clears to 0. Operand values present on any other edge have no effect.
- R3: If the multiplier loaded is 0, the pass ends at once and the very next edge is again a load edge, so the product published for that pass is 0.
- R4: On each iteration edge, the multiplicand is added to the accumulator if and only if the multiplier's bit 0 is 1. On the same edge the multiplicand shifts left by one and the multiplier shifts right by one, with a zero entering at the top.
- R5: A pass whose multiplier has its highest set bit at index k (0 to N-1) takes exactly k+2 clock cycles from one load edge to the next. The worst case is therefore N+1 cycles, within an N+2 cycle bound.
- R6: The value published on a load edge equals the exact unsigned product of the operands sampled on the previous load edge. Between load edges the product output is held unchanged.
- R7: Passes repeat forever with no start input. A new operand pair is sampled on the edge after each completed pass.
- R8: The controller is Moore. Its next state depends only on the look-ahead "multiplier nonzero" and "multiplier odd" status bits. In the add state the multiplier is odd, and in the shift-only state it is even and nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | N | Multiplicand operand, sampled on load edges |
| op_b | input | N | Multiplier operand, sampled on load edges |
| product | output | 2N | Registered product of the last completed pass |

## Verification
On every cycle, the assertions check the following:
- each iteration applies the conditional add and both shifts;
- a load edge performs all four transfers together;
- the product holds steady between load edges;
- the controller state agrees with the multiplier's parity and zero status;
- a pass exits on the edge after its last set bit shifts out.

Some behaviours can only be shown by the bench's scenarios, which compare the port each cycle against a behavioural model of the algorithm. These are the exact product values, the k+2 cycle pass length seen from outside, and the fact that operand changes in the middle of a pass are ignored. The scenarios that show them use a zero multiplier, an all-ones multiplier, single-bit multipliers, the maximum operands, and random operands changed every cycle.

// File: rtl/early_mult_pkg.sv
package early_mult_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2
  } em_state_e;

  typedef struct packed {
    logic load;
    logic step;
    logic add;
  } em_ctrl_t;

endpackage

// File: rtl/em_ctrl.sv
module em_ctrl
  import early_mult_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      nz_next,
  input  logic      odd_next,
  output em_state_e state,
  output em_ctrl_t  ctrl
);

  em_state_e state_nxt;

  // Branch on the status of the value the multiplier takes at this edge.
  always_comb begin
    if (!nz_next)      state_nxt = ST_LOAD;
    else if (odd_next) state_nxt = ST_ADD;
    else               state_nxt = ST_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_LOAD;
    else     state <= state_nxt;
  end

  // Moore outputs: a function of the state register only.
  always_comb begin
    ctrl = '0;
    case (state)
      ST_ADD:   begin ctrl.step = 1'b1; ctrl.add = 1'b1; end
      ST_SHIFT: ctrl.step = 1'b1;
      default:  ctrl.load = 1'b1;
    endcase
  end

endmodule

// File: rtl/em_lookahead.sv
module em_lookahead #(
  parameter int N = 8
) (
  input  logic         load,
  input  logic         step,
  input  logic [N-1:0] op_b,
  input  logic [N-1:0] mplier,
  output logic         nz_next,
  output logic         odd_next
);

  logic [N-1:0] mplier_nxt;

  always_comb begin
    if (load)      mplier_nxt = op_b;
    else if (step) mplier_nxt = mplier >> 1;
    else           mplier_nxt = mplier;
  end

  assign nz_next  = |mplier_nxt;
  assign odd_next = mplier_nxt[0];

endmodule

// File: rtl/em_datapath.sv
module em_datapath
  import early_mult_pkg::*;
#(
  parameter int N = 8,
  localparam int PW = 2 * N
) (
  input  logic          clk,
  input  logic          rst,
  input  em_ctrl_t      ctrl,
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  output logic [PW-1:0] mcand,
  output logic [N-1:0]  mplier,
  output logic [PW-1:0] acc,
  output logic [PW-1:0] hold
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand <= '0;
      mplier <= '0;
    end else if (ctrl.load) begin
      mcand <= {{N{1'b0}}, op_a};
      mplier <= op_b;
    end else if (ctrl.step) begin
      mcand <= mcand << 1;
      mplier <= mplier >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      hold <= '0;
    end else if (ctrl.load) begin
      hold <= acc;
      acc <= '0;
    end else if (ctrl.add) begin
      acc <= acc + mcand;
    end
  end

endmodule

// File: rtl/early_mult.sv
module early_mult
  import early_mult_pkg::*;
#(
  parameter int N = 8,
  localparam int PW = 2 * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  output logic [PW-1:0] product
);

  em_state_e     state;
  em_ctrl_t      ctrl;
  logic          nz_next;
  logic          odd_next;
  logic [PW-1:0] mcand;
  logic [N-1:0]  mplier;
  logic [PW-1:0] acc;

  em_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .nz_next  (nz_next),
    .odd_next (odd_next),
    .state    (state),
    .ctrl     (ctrl)
  );

  em_lookahead #(.N(N)) u_look (
    .load     (ctrl.load),
    .step     (ctrl.step),
    .op_b     (op_b),
    .mplier   (mplier),
    .nz_next  (nz_next),
    .odd_next (odd_next)
  );

  em_datapath #(.N(N)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .op_a   (op_a),
    .op_b   (op_b),
    .mcand  (mcand),
    .mplier (mplier),
    .acc    (acc),
    .hold   (product)
  );

endmodule

// File: rtl/early_mult_chk.sv
module early_mult_chk
  import early_mult_pkg::*;
#(
  parameter int N = 8,
  localparam int PW = 2 * N
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  op_a,
  input logic [N-1:0]  op_b,
  input em_state_e     state,
  input logic [PW-1:0] mcand,
  input logic [N-1:0]  mplier,
  input logic [PW-1:0] acc,
  input logic [PW-1:0] product
);

  // R1: registers are clear on the first cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (product == '0 && acc == '0 && mplier == '0 && state == ST_LOAD));

  // R2: load edge moves all four registers together
  p_load_xfer_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |=> (acc == '0 && product == $past(acc)
      && mcand == {{N{1'b0}}, $past(op_a)} && mplier == $past(op_b)));

  // R3: a zero multiplier sends the controller straight back to load
  p_zero_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && op_b == '0) |=> (state == ST_LOAD));

  // R4: both shifts happen on every iteration edge
  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (state != ST_LOAD) |=> (mplier == ($past(mplier) >> 1) && mcand == ($past(mcand) << 1)));

  // R4: add only in the add state
  p_add_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADD) |=> (acc == $past(acc) + $past(mcand)));

  p_noadd_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |=> $stable(acc));

  // R5: exit on the edge where the last set bit leaves
  p_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (state != ST_LOAD && (mplier >> 1) == '0) |=> (state == ST_LOAD));

  // R6: product only changes on load edges
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state != ST_LOAD) |=> $stable(product));

  // R8: controller state agrees with multiplier status
  p_add_odd_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADD) |-> mplier[0]);

  p_shift_even_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> (!mplier[0] && mplier != '0));

endmodule

bind early_mult early_mult_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_a    (op_a),
  .op_b    (op_b),
  .state   (state),
  .mcand   (mcand),
  .mplier  (mplier),
  .acc     (acc),
  .product (product)
);

// File: tb/tb_early_mult.sv
`timescale 1ns/1ps
module tb_early_mult;

  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  op_a = '0;
  logic [N-1:0]  op_b = '0;
  logic [PW-1:0] product;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  bit    cmp_en = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  early_mult #(.N(N)) dut (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
  );

  // Behavioural model of the algorithm: one edge per load or per iteration.
  int m_a, m_b, m_c, m_h;
  bit m_loop;
  always @(posedge clk) begin
    if (rst) begin
      m_a = 0; m_b = 0; m_c = 0; m_h = 0; m_loop = 0;
    end else if (!m_loop) begin
      m_h = m_c; m_a = int'(op_a); m_b = int'(op_b); m_c = 0;
      m_loop = (m_b != 0);
    end else begin
      if ((m_b & 1) != 0) m_c = m_c + m_a;
      m_a = m_a << 1;
      m_b = m_b >> 1;
      m_loop = (m_b != 0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: product actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) chk(cur_tag, int'(product), m_h);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    op_a = 8'd3; op_b = 8'hFF;
    wait_cycles(3);
    chk("R1", int'(product), 0);
    @(negedge clk) rst = 1'b0;
    // R5: all-ones multiplier takes N+1 cycles; product appears on edge 10
    for (int e = 1; e <= 9; e++) begin
      @(negedge clk);
      chk("R5", int'(product), 0);
    end
    @(negedge clk);
    chk("R5", int'(product), 765);
    cmp_en = 1;
    wait_cycles(12);

    // R3: zero multiplier, one cycle per pass
    cur_tag = "R3";
    op_a = 8'd77; op_b = 8'd0;
    wait_cycles(12);
    chk("R3", int'(product), 0);

    // R4: single-bit multipliers exercise shift-only and add paths
    cur_tag = "R4";
    for (int b = 0; b < N; b++) begin
      op_a = 8'd13; op_b = 8'(1 << b);
      wait_cycles(2 * (N + 2));
      chk("R4", int'(product), 13 * (1 << b));
    end

    // R6: maximum operands
    cur_tag = "R6";
    op_a = 8'hFF; op_b = 8'hFF;
    wait_cycles(2 * (N + 2));
    chk("R6", int'(product), 65025);

    // R2: operands changing every cycle, only load-edge values count
    cur_tag = "R2";
    for (int i = 0; i < 300; i++) begin
      op_a = 8'($urandom); op_b = 8'($urandom);
      @(negedge clk);
    end

    // R7 and R8: free-running passes with mixed parity patterns
    cur_tag = "R7";
    for (int i = 0; i < 40; i++) begin
      op_a = 8'($urandom); op_b = 8'($urandom) & 8'h5A;
      wait_cycles(int'($urandom_range(1, 12)));
    end
    cur_tag = "R8";
    op_a = 8'd200; op_b = 8'hA6;
    wait_cycles(2 * (N + 2));
    chk("R8", int'(product), 200 * 166);

    // R1: reset mid-pass clears the product
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", int'(product), 0);
    rst = 1'b0;
    wait_cycles(4);
    finish_run();
  end

endmodule